// File: doc/BRIEF.md
# Rate-Matched Dual-Clock Elastic Buffer

This block moves a continuous 32-bit sample stream from a fast write clock to a slower read clock when the two sides carry exactly the same long-term word rate. In the intended use, for example, the write side offers a word on two of every three write-clock cycles and the read side takes one word on every read-clock cycle, with a 3:2 clock ratio. The storage is a 16-word dual-port memory. Each side steps its own address counter in its own clock domain. Read and write positions are never compared and never passed across domains, so the block has no full or empty flags.

The only signal that crosses between the domains is a one-shot start indication. The write side raises it once eight words (half the depth) have been accepted. The read side sees it through a two-flop synchronizer, then reads without pause. The distance between the two counters is fixed at start-up and stays fixed only while the rates match. A dedicated buffer reset clears both counters and the start state and nothing else. It is meant to be pulsed just before every capture so that each capture begins from a clean alignment.

Both stream edges use a valid qualifier and have no ready signal, because there is no back-pressure. The writer may not be stalled and must not expect any word to be refused. The reader must take a word on every cycle in which `out_valid` is high.

Top module: `ratelock_buf`

## Requirements
- R1: From buffer reset until reading starts, `out_valid` is low.
- R2: A write-clock cycle with `in_valid` low stores nothing and does not move the write position. Data presented on such cycles never reaches the output.
- R3: Both positions are 4-bit counters that wrap from 15 to 0, so a stream longer than 16 words passes through unbroken.
- R4: Reading starts only after at least 8 accepted words (half the depth) since reset. The start indication is sticky until the next buffer reset.
- R5: The start indication reaches the read domain through a two-flop synchronizer. The read port is registered, so the first output word appears one read cycle after the read position starts moving. That first word is the first word accepted after reset.
- R6: Once started, `out_valid` stays high on every read-clock cycle, and the words appear in exact write order with no skips and no repeats, provided the rates match.
- R7: `buf_rst` asserts asynchronously and is released in each domain after two edges of that domain's clock. It clears both positions and the start state. A stream sent after a reset comes out starting from that stream's own first word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| in_valid | input | 1 | Write qualifier; `in_data` is stored on each rising edge where this is high |
| in_data | input | 32 | Write data |
| rd_clk | input | 1 | Read-side clock |
| out_valid | output | 1 | High on each read cycle that carries a word |
| out_data | output | 32 | Read data |
| buf_rst | input | 1 | Active-high buffer reset, asynchronous assertion |

## Verification
The cycle in which the read side begins streaming is also a cycle in which the write side is still filling. The sync delay and the 3:2 clock phase decide how many words sit in the memory at that moment. The bench drives the 2-of-3 write pattern, with junk data on the idle cycles, against a behavioural queue. On the first valid output it judges two things: that at least eight words had been queued, and that the word equals the stream's first word. After that it pops and compares on every read cycle. A buffer reset is also pulsed in the middle of a running stream, where it collides with live reads and writes. The restarted stream must again hold back until half-full and then begin from its own first word.

// File: rtl/ratelock_pkg.sv
package ratelock_pkg;
  parameter int unsigned RL_DATA_W = 32;
  parameter int unsigned RL_DEPTH  = 16;
  parameter int unsigned RL_SYNC   = 2;
endpackage

// File: rtl/ratelock_sync.sv
// Multi-stage synchronizer with asynchronous clear; used for resets and the start flag.
module ratelock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ratelock_dpram.sv
// Simple dual-port memory: write port on wclk, registered read port on rclk.
module ratelock_dpram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk)
    if (we) store[waddr] <= wdata;

  always_ff @(posedge rclk)
    if (re) rdata <= store[raddr];
endmodule

// File: rtl/ratelock_wr_side.sv
// Write-domain position counter and sticky half-fill flag.
module ratelock_wr_side #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned HALF   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic              primed
);
  localparam logic [ADDR_W-1:0] LAST_FILL = ADDR_W'(HALF - 1);

  logic [ADDR_W-1:0] wpos;
  logic              primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos     <= '0;
      primed_q <= 1'b0;
    end else if (in_valid) begin
      wpos <= wpos + 1'b1;
      if (wpos == LAST_FILL) primed_q <= 1'b1;
    end
  end

  assign we     = in_valid;
  assign waddr  = wpos;
  assign primed = primed_q;

  assert_idle_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(wpos));
  assert_wr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wpos == '1) |=> wpos == '0);
  assert_primed_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);
endmodule

// File: rtl/ratelock_rd_side.sv
// Read-domain position counter, enabled once the synchronized start flag is seen.
module ratelock_rd_side #(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              out_valid
);
  logic [ADDR_W-1:0] rpos;
  logic              vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpos  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= go;
      if (go) rpos <= rpos + 1'b1;
    end
  end

  assign re        = go;
  assign raddr     = rpos;
  assign out_valid = vld_q;

  assert_idle_pos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> rpos == '0);
  assert_first_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vld_q) |-> rpos == ADDR_W'(1));
  assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> vld_q);
  assert_rd_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> rpos == $past(rpos) + 1'b1);
endmodule

// File: rtl/ratelock_buf.sv
module ratelock_buf
  import ratelock_pkg::*;
#(
  parameter int unsigned DATA_W = RL_DATA_W,
  parameter int unsigned DEPTH  = RL_DEPTH,
  parameter int unsigned SYNC_N = RL_SYNC
) (
  input  logic              wr_clk,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_clk,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              buf_rst
);
  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned HALF   = DEPTH / 2;

  logic              wr_rst_n, rd_rst_n;
  logic              we, re, primed, go;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              in_valid_g;

  ratelock_sync #(.STAGES(SYNC_N)) u_wr_rst (
    .clk(wr_clk), .rst_n(~buf_rst), .d(1'b1), .q(wr_rst_n));
  ratelock_sync #(.STAGES(SYNC_N)) u_rd_rst (
    .clk(rd_clk), .rst_n(~buf_rst), .d(1'b1), .q(rd_rst_n));

  assign in_valid_g = in_valid & wr_rst_n;

  ratelock_wr_side #(.ADDR_W(ADDR_W), .HALF(HALF)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .in_valid(in_valid_g),
    .we(we), .waddr(waddr), .primed(primed));

  ratelock_sync #(.STAGES(SYNC_N)) u_go_sync (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(primed), .q(go));

  ratelock_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .go(go),
    .re(re), .raddr(raddr), .out_valid(out_valid));

  ratelock_dpram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(in_data),
    .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(out_data));
endmodule

// File: tb/ratelock_buf_bench.sv
`timescale 1ns/1ps
module ratelock_buf_bench;
  logic        wr_clk = 1'b0;
  logic        rd_clk = 1'b0;
  logic        buf_rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  always #4 wr_clk = ~wr_clk;   // 125 MHz write clock
  always #6 rd_clk = ~rd_clk;   // 2/3 rate read clock

  ratelock_buf u_ratelock_buf (
    .wr_clk(wr_clk), .in_valid(in_valid), .in_data(in_data),
    .rd_clk(rd_clk), .out_valid(out_valid), .out_data(out_data),
    .buf_rst(buf_rst));

  int          nchk = 0;
  int          nfail = 0;
  logic [31:0] model_q[$];
  int          written = 0;
  bit          chk_en = 1'b0;
  bit          started = 1'b0;
  logic [31:0] base = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: queue of accepted words, popped on every valid read cycle.
  always @(negedge rd_clk) begin
    if (chk_en) begin
      if (out_valid) begin
        if (!started) begin
          started = 1'b1;
          chk(written >= 8, "R4 start before half fill", 32'(written), 32'd8);
          chk(out_data == base, "R5/R7 first word of stream", out_data, base);
        end
        if (model_q.size() == 0) begin
          chk(1'b0, "R6 output with no word queued", out_data, 32'hx);
        end else begin
          logic [31:0] exp;
          exp = model_q.pop_front();
          chk(out_data == exp, "R2/R3/R6 ordered word", out_data, exp);
        end
      end else if (started) begin
        chk(1'b0, "R6 gap in output stream", {31'd0, out_valid}, 32'd1);
      end
    end
  end

  task automatic stream(input logic [31:0] b, input int n);
    int k;
    int sent;
    k = 0;
    sent = 0;
    base = b;
    written = 0;
    started = 1'b0;
    model_q.delete();
    chk_en = 1'b1;
    while (sent < n) begin
      @(negedge wr_clk);
      if (k % 3 != 2) begin
        in_valid = 1'b1;
        in_data  = b + 32'(sent);
        model_q.push_back(b + 32'(sent));
        sent++;
        written++;
      end else begin
        in_valid = 1'b0;
        in_data  = 32'hBAD0_0000 | 32'(k);   // junk on idle cycles (R2)
      end
      k++;
    end
    @(negedge wr_clk);
    chk_en   = 1'b0;
    in_valid = 1'b0;
    chk(started, "R6 stream never started", {31'd0, started}, 32'd1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #200000;
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge wr_clk);
    chk(out_valid == 1'b0, "R1 valid low in reset", {31'd0, out_valid}, 32'd0);
    buf_rst = 1'b0;
    repeat (4) begin
      @(negedge rd_clk);
      chk(out_valid == 1'b0, "R1 valid low before start", {31'd0, out_valid}, 32'd0);
    end
    stream(32'h0000_0000, 300);      // long run: both positions wrap many times (R3)

    @(negedge wr_clk);
    buf_rst = 1'b1;                  // reset mid-stream while reads still run (R7)
    @(negedge rd_clk);
    chk(out_valid == 1'b0, "R7 reset clears output stream", {31'd0, out_valid}, 32'd0);
    repeat (3) @(negedge wr_clk);
    buf_rst = 1'b0;
    repeat (4) begin
      @(negedge rd_clk);
      chk(out_valid == 1'b0, "R1 valid low after second reset", {31'd0, out_valid}, 32'd0);
    end
    stream(32'h4000_0000, 200);

    repeat (10) @(negedge wr_clk);
    summary();
    $finish;
  end
endmodule